// File: doc/BRIEF.md
# Shadowed SRAM store/recall controller

This block is a byte-wide static memory in which every word has a nonvolatile shadow copy. A host reaches the SRAM through a synchronous, active-low style port (chip enable, output enable, write enable, address, data in, data out with an output-enable qualifier). The block moves the whole array between SRAM and shadow in one step. A STORE copies SRAM into the shadow. A RECALL first clears the SRAM and then loads it from the shadow. The depth is a parameter and is kept small for simulation.

A STORE starts when a fixed six-read address sequence is completed, when the open-drain store/busy line is pulled low by the host, or when the power-good input falls. A RECALL starts when power-good rises, or when a second six-read sequence is completed. While a copy runs, the block pulls the store/busy line low, keeps the data bus undriven and ignores every access. A power loss that occurs during a RECALL is held and becomes a STORE as soon as the RECALL ends. The SRAM is reachable only while power-good is high.

Top module: `nvsram_ctrl`

## Requirements
- R1: After reset the store/busy pull-down (`store_pin_pull`) and the data output enable (`dq_oe`) are both low.
- R2: When the block is idle and powered, an access with `ce_n`=0 and `we_n`=0 writes `dq_in` to `addr`. An access with `ce_n`=0 and `we_n`=1 is a read. For a read, `dq_oe` is high and `dq_out` holds the addressed word in the next cycle, but only if `oe_n`=0 during the access.
- R3: A rise of `pwr_ok` starts a RECALL. `store_pin_pull` is high for exactly CLEAR_CYC+LOAD_CYC cycles, starting the cycle after the edge. Afterwards every SRAM word equals its shadow word, and the SRAM has been all zero between the two phases.
- R4: Six consecutive reads to 0x15, 0x2A, 0x07, 0x38, 0x1C and 0x23 start a STORE. `store_pin_pull` is high for exactly STORE_CYC cycles, starting the cycle after the last read. The shadow then holds the SRAM contents.
- R5: The same first five reads followed by a read of 0x31 start a RECALL that lasts CLEAR_CYC+LOAD_CYC cycles.
- R6: Any write, or any read to an address other than the next expected one, sends the matcher back to its first step. The offending read is not counted as a first step. A later complete sequence still works.
- R7: Pulling the store line low while the block is idle starts a STORE of STORE_CYC cycles. The block ignores the line while it drives the line itself.
- R8: A fall of `pwr_ok` while idle starts a STORE of STORE_CYC cycles.
- R9: While busy, `dq_oe` stays low and writes and reads are ignored.
- R10: A RECALL never alters the shadow. Repeated RECALLs return the same data.
- R11: A fall of `pwr_ok` during a RECALL queues a STORE. That STORE follows with no idle cycle, so the busy time totals CLEAR_CYC+LOAD_CYC+STORE_CYC.
- R12: While `pwr_ok` is low, accesses are ignored and `dq_oe` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Word address |
| dq_in | input | DATA_W | Write data |
| dq_out | output | DATA_W | Read data |
| dq_oe | output | 1 | Read data is driven |
| store_pin_in | input | 1 | Sensed level of the open-drain store/busy line |
| store_pin_pull | output | 1 | Pulls the store/busy line low while busy |
| pwr_ok | input | 1 | Supply above threshold |

## Verification
The bench goes after the matcher's abort rules. In one case a wrong read equals the first sequence address. A design that counted that read as a fresh first step would start a STORE where none is due. It measures every busy window to the cycle. This catches an off-by-one in the phase counters, and also a queued STORE that is dropped or separated from the RECALL by an idle gap. Accesses are issued during a copy and while power is down. A design that leaks one of them would change a word or drive the bus, and a later read exposes this. Alternating recalls with SRAM edits shows whether a RECALL writes back into the shadow.

// File: rtl/nvs_pkg.sv
// Shared definitions for the shadowed SRAM controller: copy-engine state
// encoding and the fixed command address sequences (6-bit addresses).
package nvs_pkg;
    localparam int SEQ_LEN = 6;
    localparam int SEQ_AW  = 6;

    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_STORE = 2'd1,
        ENG_CLEAR = 2'd2,
        ENG_LOAD  = 2'd3
    } eng_state_t;

    localparam logic [SEQ_AW-1:0] STORE_TAIL  = 6'h23;
    localparam logic [SEQ_AW-1:0] RECALL_TAIL = 6'h31;

    // Address expected at shared step 0..SEQ_LEN-2.
    function automatic logic [SEQ_AW-1:0] seq_addr(input int step);
        logic [SEQ_AW-1:0] a;
        case (step)
            0:       a = 6'h15;
            1:       a = 6'h2A;
            2:       a = 6'h07;
            3:       a = 6'h38;
            default: a = 6'h1C;
        endcase
        return a;
    endfunction
endpackage

// File: rtl/nvs_seq_match.sv
// Command sequence matcher. Follows the shared read-address prefix and flags
// a STORE or RECALL hit on the final read. Assumes ADDR_W >= 6 and that
// accesses are already qualified (idle and powered). Any write or unexpected
// read returns it to step 0; a busy engine holds it at step 0.
module nvs_seq_match
    import nvs_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort,
    input  logic              rd_acc,
    input  logic              wr_acc,
    input  logic [ADDR_W-1:0] addr,
    output logic              store_hit,
    output logic              recall_hit
);
    localparam int SW = $clog2(SEQ_LEN);
    localparam logic [SW-1:0] LAST = SW'(SEQ_LEN - 1);

    logic [SW-1:0] step;
    logic          step_match;

    // Decode the current read against the expected address.
    always_comb begin
        step_match = rd_acc && (step < LAST) &&
                     (addr == ADDR_W'(seq_addr(int'(step))));
        store_hit  = rd_acc && (step == LAST) && (addr == ADDR_W'(STORE_TAIL));
        recall_hit = rd_acc && (step == LAST) && (addr == ADDR_W'(RECALL_TAIL));
    end

    // Advance on a matching read, fall back to step 0 on anything else.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            step <= '0;
        end else if (wr_acc) begin
            step <= '0;
        end else if (rd_acc) begin
            step <= step_match ? step + SW'(1) : '0;
        end
    end

    assert_step_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        step <= LAST);
    assert_write_aborts_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_acc |=> step == '0);
    assert_hit_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(store_hit && recall_hit));
endmodule

// File: rtl/nvs_copy_engine.sv
// Copy engine. Chooses between STORE and RECALL and times each phase with a
// down counter. Emits one-cycle strobes in the last cycle of each phase.
// Assumes pin_low is already masked while the engine drives the line.
// A power fall during RECALL is queued and runs right after it.
module nvs_copy_engine
    import nvs_pkg::*;
#(
    parameter int STORE_CYC = 20,
    parameter int CLEAR_CYC = 4,
    parameter int LOAD_CYC  = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_ok,
    input  logic pin_low,
    input  logic seq_store,
    input  logic seq_recall,
    output logic busy,
    output logic do_store,
    output logic do_clear,
    output logic do_load
);
    localparam int MAXC = (STORE_CYC > CLEAR_CYC) ?
                          ((STORE_CYC > LOAD_CYC) ? STORE_CYC : LOAD_CYC) :
                          ((CLEAR_CYC > LOAD_CYC) ? CLEAR_CYC : LOAD_CYC);
    localparam int CW = $clog2(MAXC + 1);

    eng_state_t    state;
    logic [CW-1:0] cnt;
    logic          pwr_q;
    logic          pend;
    logic          pwr_fall, pwr_rise, want_store, want_recall, last;

    // Trigger decode and phase-end strobes.
    always_comb begin
        pwr_fall    = pwr_q && !pwr_ok;
        pwr_rise    = !pwr_q && pwr_ok;
        want_store  = pwr_fall || pin_low || seq_store;
        want_recall = pwr_rise || seq_recall;
        last        = (cnt == '0);
        busy        = (state != ENG_IDLE);
        do_store    = (state == ENG_STORE) && last;
        do_clear    = (state == ENG_CLEAR) && last;
        do_load     = (state == ENG_LOAD)  && last;
    end

    // Phase sequencing, counters and queued store.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ENG_IDLE;
            cnt   <= '0;
            pwr_q <= 1'b0;
            pend  <= 1'b0;
        end else begin
            pwr_q <= pwr_ok;
            case (state)
                ENG_IDLE: begin
                    if (want_store) begin
                        state <= ENG_STORE;
                        cnt   <= CW'(STORE_CYC - 1);
                    end else if (want_recall) begin
                        state <= ENG_CLEAR;
                        cnt   <= CW'(CLEAR_CYC - 1);
                    end
                end
                ENG_STORE: begin
                    if (last) state <= ENG_IDLE;
                    else      cnt   <= cnt - CW'(1);
                end
                ENG_CLEAR: begin
                    pend <= pend || pwr_fall;
                    if (last) begin
                        state <= ENG_LOAD;
                        cnt   <= CW'(LOAD_CYC - 1);
                    end else begin
                        cnt <= cnt - CW'(1);
                    end
                end
                default: begin
                    if (last) begin
                        pend <= 1'b0;
                        if (pend || pwr_fall) begin
                            state <= ENG_STORE;
                            cnt   <= CW'(STORE_CYC - 1);
                        end else begin
                            state <= ENG_IDLE;
                        end
                    end else begin
                        pend <= pend || pwr_fall;
                        cnt  <= cnt - CW'(1);
                    end
                end
            endcase
        end
    end

    assert_no_pend_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        state == ENG_IDLE |-> !pend);
    assert_store_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ENG_STORE && !last) |=> state == ENG_STORE);
    assert_recall_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        do_clear |=> state == ENG_LOAD);
    assert_queued_store_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (do_load && pend) |=> state == ENG_STORE);
endmodule

// File: rtl/nvs_cell_array.sv
// SRAM and shadow arrays. Performs user word access and the whole-array
// copies: shadow <= sram on store, clear then shadow -> sram on recall.
// Both arrays reset to zero so that simulation is deterministic.
module nvs_cell_array #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              do_store,
    input  logic              do_clear,
    input  logic              do_load,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DEPTH-1:0][DATA_W-1:0] sram;
    logic [DEPTH-1:0][DATA_W-1:0] shadow;

    // Word access and bulk copies; bulk copies and access never overlap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sram   <= '0;
            shadow <= '0;
            rdata  <= '0;
        end else begin
            if (do_store) shadow <= sram;
            if (do_clear)      sram <= '0;
            else if (do_load)  sram <= shadow;
            else if (wr_en)    sram[addr] <= wdata;
            if (rd_en) rdata <= sram[addr];
        end
    end

    assert_shadow_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !do_store |=> $stable(shadow));
    assert_cleared_R3: assert property (@(posedge clk) disable iff (!rst_n)
        do_clear |=> sram == '0);
    assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !do_clear && !do_load) |=> sram[$past(addr)] == $past(wdata));
endmodule

// File: rtl/nvsram_ctrl.sv
// Top of the shadowed SRAM controller. Qualifies host accesses (idle and
// powered) and drives the open-drain store/busy line and read data enable.
// Assumes synchronous host inputs and ADDR_W >= 6.
module nvsram_ctrl #(
    parameter int ADDR_W    = 6,
    parameter int DATA_W    = 8,
    parameter int STORE_CYC = 20,
    parameter int CLEAR_CYC = 4,
    parameter int LOAD_CYC  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    input  logic              store_pin_in,
    output logic              store_pin_pull,
    input  logic              pwr_ok
);
    logic busy, io_ok, rd_acc, wr_acc, drive_q, pin_low;
    logic seq_store, seq_recall, do_store, do_clear, do_load;

    // Access qualification and pin sensing.
    always_comb begin
        io_ok          = !busy && pwr_ok && !ce_n;
        wr_acc         = io_ok && !we_n;
        rd_acc         = io_ok && we_n;
        pin_low        = !store_pin_in && !busy;
        store_pin_pull = busy;
        dq_oe          = drive_q && !busy && pwr_ok;
    end

    // Register the output-enable of a read for the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) drive_q <= 1'b0;
        else        drive_q <= rd_acc && !oe_n;
    end

    nvs_seq_match #(.ADDR_W(ADDR_W)) u_match (
        .clk(clk), .rst_n(rst_n), .abort(busy), .rd_acc(rd_acc), .wr_acc(wr_acc),
        .addr(addr), .store_hit(seq_store), .recall_hit(seq_recall)
    );

    nvs_copy_engine #(.STORE_CYC(STORE_CYC), .CLEAR_CYC(CLEAR_CYC), .LOAD_CYC(LOAD_CYC)) u_engine (
        .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .pin_low(pin_low),
        .seq_store(seq_store), .seq_recall(seq_recall), .busy(busy),
        .do_store(do_store), .do_clear(do_clear), .do_load(do_load)
    );

    nvs_cell_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cells (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_acc), .rd_en(rd_acc), .addr(addr),
        .wdata(dq_in), .do_store(do_store), .do_clear(do_clear), .do_load(do_load),
        .rdata(dq_out)
    );

    assert_lockout_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !dq_oe);
    assert_drive_after_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> $past(rd_acc && !oe_n));
    assert_unpowered_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok |=> !$past(wr_acc) && !$past(rd_acc));
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> !store_pin_pull && !dq_oe);
endmodule

// File: tb/test_nvsram_ctrl.sv
`timescale 1ns/1ps
module test_nvsram_ctrl;
    localparam int AW = 6, DEPTH = 64, ST = 20, CL = 4, LD = 12;
    localparam logic [5:0] SEQA [5] = '{6'h15, 6'h2A, 6'h07, 6'h38, 6'h1C};
    localparam logic [5:0] TAIL_ST = 6'h23, TAIL_RC = 6'h31;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n, ce_n, oe_n, we_n, dq_oe, pwr_ok, host_store_n, pin_pull;
    logic [AW-1:0] addr;
    logic [7:0] dq_in, dq_out;
    wire pin_line = host_store_n & ~pin_pull;

    nvsram_ctrl #(.ADDR_W(AW), .DATA_W(8), .STORE_CYC(ST), .CLEAR_CYC(CL), .LOAD_CYC(LD)) i_nvsram_ctrl (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .addr(addr),
        .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe), .store_pin_in(pin_line),
        .store_pin_pull(pin_pull), .pwr_ok(pwr_ok)
    );

    int vectors = 0, errors = 0;
    bit done = 0;
    logic [7:0] sram_m [DEPTH];
    logic [7:0] shadow_m [DEPTH];
    logic [7:0] exp_q [$];
    string tag_q [$];

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Monitor: every driven read is popped from the scoreboard and compared.
    always @(negedge clk) begin
        if (rst_n && !done && dq_oe) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9", "unexpected bus drive", int'(dq_out), 0);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(dq_out == e, t, "read data", int'(dq_out), int'(e));
            end
        end
    end

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        ce_n = 0; we_n = 0; oe_n = 1; addr = a; dq_in = d;
        @(negedge clk);
        ce_n = 1; we_n = 1;
    endtask

    task automatic wr_m(input logic [AW-1:0] a, input logic [7:0] d);
        wr(a, d);
        sram_m[a] = d;
    endtask

    task automatic rd(input logic [AW-1:0] a, input bit expect_data, input string tag);
        ce_n = 0; we_n = 1; oe_n = 0; addr = a;
        if (expect_data) begin
            exp_q.push_back(sram_m[a]);
            tag_q.push_back(tag);
        end
        @(negedge clk);
        ce_n = 1; oe_n = 1;
    endtask

    task automatic prefix(input int from, input int upto, input string tag);
        for (int k = from; k <= upto; k++) rd(AW'(SEQA[k]), 1'b1, tag);
    endtask

    task automatic expect_busy(input int exp, input string tag);
        int n = 0;
        while (pin_pull && n < 1000) begin
            n++;
            @(negedge clk);
        end
        check(n == exp, tag, "busy cycles", n, exp);
    endtask

    task automatic do_recall_model();
        for (int i = 0; i < DEPTH; i++) sram_m[i] = shadow_m[i];
    endtask

    task automatic do_store_model();
        for (int i = 0; i < DEPTH; i++) shadow_m[i] = sram_m[i];
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    endtask

    initial begin
        #(4 * 100000);
        vectors++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 0; ce_n = 1; oe_n = 1; we_n = 1; addr = '0; dq_in = '0;
        pwr_ok = 0; host_store_n = 1;
        for (int i = 0; i < DEPTH; i++) begin sram_m[i] = 8'h00; shadow_m[i] = 8'h00; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(!pin_pull && !dq_oe, "R1", "idle after reset", {pin_pull, dq_oe}, 0);

        // R12: access while unpowered has no effect
        wr(5, 8'h55);
        rd(5, 1'b0, "R12");
        check(!dq_oe, "R12", "no drive while unpowered", dq_oe, 0);

        // R3: power-up recall
        pwr_ok = 1;
        @(negedge clk);
        expect_busy(CL + LD, "R3");
        do_recall_model();
        rd(5, 1'b1, "R12");

        // R2: fill and read back
        for (int i = 0; i < DEPTH; i++) wr_m(AW'(i), 8'(i * 7 + 3));
        for (int i = 0; i < DEPTH; i += 5) rd(AW'(i), 1'b1, "R2");
        ce_n = 0; we_n = 1; oe_n = 1; addr = 3;
        @(negedge clk);
        ce_n = 1;
        check(!dq_oe, "R2", "no drive with output enable off", dq_oe, 0);

        // R4: sequence store
        prefix(0, 4, "R4");
        rd(AW'(TAIL_ST), 1'b0, "R4");
        expect_busy(ST, "R4");
        do_store_model();

        // R5: overwrite, then sequence recall restores
        for (int i = 0; i < DEPTH; i++) wr_m(AW'(i), 8'(~(i * 7 + 3)));
        rd(7, 1'b1, "R2");
        prefix(0, 4, "R5");
        rd(AW'(TAIL_RC), 1'b0, "R5");
        expect_busy(CL + LD, "R5");
        do_recall_model();
        for (int i = 0; i < DEPTH; i++) rd(AW'(i), 1'b1, "R5");

        // R10: recall does not touch shadow; repeated recalls agree
        wr_m(9, 8'hA5);
        prefix(0, 4, "R10");
        rd(AW'(TAIL_RC), 1'b0, "R10");
        expect_busy(CL + LD, "R10");
        do_recall_model();
        prefix(0, 4, "R10");
        rd(AW'(TAIL_RC), 1'b0, "R10");
        expect_busy(CL + LD, "R10");
        do_recall_model();
        rd(9, 1'b1, "R10");
        rd(0, 1'b1, "R10");

        // R6: wrong address aborts
        prefix(0, 2, "R6");
        rd(0, 1'b1, "R6");
        prefix(3, 4, "R6");
        rd(AW'(TAIL_ST), 1'b1, "R6");
        check(!pin_pull, "R6", "wrong read aborted", pin_pull, 0);
        // R6: write aborts
        prefix(0, 1, "R6");
        wr_m(40, 8'h40);
        prefix(2, 4, "R6");
        rd(AW'(TAIL_ST), 1'b1, "R6");
        check(!pin_pull, "R6", "write aborted", pin_pull, 0);
        // R6: offending read is not a first step
        prefix(0, 1, "R6");
        rd(AW'(SEQA[0]), 1'b1, "R6");
        prefix(1, 4, "R6");
        rd(AW'(TAIL_ST), 1'b1, "R6");
        check(!pin_pull, "R6", "mismatch not counted as first step", pin_pull, 0);
        // R6: full sequence still works afterwards
        prefix(0, 4, "R6");
        rd(AW'(TAIL_ST), 1'b0, "R6");
        expect_busy(ST, "R6");
        do_store_model();

        // R7 + R9: pin store with access attempts while busy
        wr_m(0, 8'h3C);
        host_store_n = 0;
        @(negedge clk);
        host_store_n = 1;
        begin
            int n = 0;
            while (pin_pull && n < 1000) begin
                ce_n = 0; oe_n = 0; we_n = n[0]; addr = 0; dq_in = 8'hEE;
                n++;
                @(negedge clk);
                check(!dq_oe, "R9", "bus driven while busy", dq_oe, 0);
            end
            ce_n = 1; oe_n = 1; we_n = 1;
            check(n == ST, "R7", "pin store busy cycles", n, ST);
        end
        do_store_model();
        rd(0, 1'b1, "R9");

        // R8: power fall store, R12 while down, R3 on return
        wr_m(1, 8'h77);
        pwr_ok = 0;
        @(negedge clk);
        expect_busy(ST, "R8");
        do_store_model();
        wr(1, 8'h00);
        rd(1, 1'b0, "R12");
        check(!dq_oe, "R12", "no drive while unpowered", dq_oe, 0);
        pwr_ok = 1;
        @(negedge clk);
        expect_busy(CL + LD, "R3");
        do_recall_model();
        rd(1, 1'b1, "R8");
        rd(0, 1'b1, "R8");

        // R11: power fall during recall queues a store
        wr_m(2, 8'h99);
        prefix(0, 4, "R11");
        rd(AW'(TAIL_RC), 1'b0, "R11");
        begin
            int n = 0;
            while (pin_pull && n < 1000) begin
                if (n == 3) pwr_ok = 0;
                n++;
                @(negedge clk);
            end
            check(n == CL + LD + ST, "R11", "recall plus queued store", n, CL + LD + ST);
        end
        do_recall_model();
        do_store_model();
        pwr_ok = 1;
        @(negedge clk);
        expect_busy(CL + LD, "R11");
        do_recall_model();
        rd(2, 1'b1, "R11");
        rd(9, 1'b1, "R11");

        @(negedge clk);
        @(negedge clk);
        check(exp_q.size() == 0, "R2", "scoreboard drained", exp_q.size(), 0);
        finish_run();
    end
endmodule